// File: doc/BRIEF.md
# Class-Latency Issue Interlock

This unit sits at the issue stage of a single-issue, in-order pipeline. Each cycle it looks at the decoded instruction: its class, up to two source register numbers and a destination register. It then either lets the instruction issue or holds it in decode and sends a bubble down the pipe. The unit keeps a countdown and a producer class for each of 32 integer and 32 floating-point registers. How far apart a producer and a consumer must be comes from a table indexed by the producer's class and the consumer's class, not from one fixed forwarding rule.

Each class sets which register file each operand field names. Integer ops read srcA and srcB and write dst, all in the integer file. FP ALU ops read and write the FP file. A double load reads an integer base on srcA and writes an FP dst. A double store reads an integer base on srcA and FP data on srcB. A branch reads an integer srcA. A NOP reads and writes nothing. Integer register 0 never raises a hazard. The instruction in a branch's delay slot always issues.

Top module: `ilk_top`

## Requirements
- R1: After reset every register is free, so the first valid instruction issues in its first decode cycle, whatever it reads.
- R2: An FP ALU op (class code 1) that reads the FP destination of an earlier FP ALU op issues no sooner than 4 cycles after it, leaving 3 cycles between them.
- R3: A double store (class code 3) whose srcB data is the FP destination of an FP ALU op issues no sooner than 3 cycles after the producer.
- R4: An FP ALU op that reads the FP destination of a double load (class code 2) issues no sooner than 2 cycles after the load.
- R5: A double load feeding a store's data needs no gap. An integer op (class code 0) feeding another integer op needs no gap. Each issues in the very next cycle.
- R6: A store's srcA base is looked up in the integer file. An FP producer writing FP register n never stalls a store whose base is integer register n.
- R7: The first valid instruction after an issued branch (class code 4) issues at once, even if it depends on a producer that is still counting down.
- R8: While stalled, issue is low and stall and bubble are high. A stall changes no countdown, so the number of stall cycles is exactly the required gap minus the independent cycles already elapsed.
- R9: The vector add-scalar loop (load, FP add, store, integer decrement, branch, slot NOP) takes 9 cycles per iteration. That is 1 stall before the add and 2 before the store.
- R10: With decValid low, issue and stall are low and bubble is high.
- R11: Class codes 5 to 7 are NOPs. They read nothing and write nothing, and always issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode slot holds an instruction |
| decClass | input | 3 | Instruction class code |
| decSrcA | input | 5 | First source register number |
| decSrcB | input | 5 | Second source register number |
| decDst | input | 5 | Destination register number |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Valid instruction held in decode |
| bubble | output | 1 | No instruction goes forward this cycle |

## Verification
Two functions can act in the same cycle: the delay-slot override and a countdown that is still live. This happens when a branch is placed right after an FP ALU producer and a dependent FP ALU op goes into the slot. Without the override that op would need 2 stalls. The bench expects it to issue with zero stall cycles. A separate sweep over producer class, consumer class and 0 to 3 independent fillers compares each stall count with the gap worked out from the latency table.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  localparam int CLS_W = 3;
  localparam int CNT_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT    = 3'd0,
    CLS_FPALU  = 3'd1,
    CLS_LOADD  = 3'd2,
    CLS_STORED = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_NOP    = 3'd5
  } instrClass_e;

  // Strobes from control to scoreboard datapath
  typedef struct packed {
    logic rdFpA;
    logic rdFpB;
    logic wrEn;
    logic wrFp;
  } sbStrobe_t;

  // Required spacing (cycles between producer and consumer)
  function automatic logic [CNT_W-1:0] needGap(input logic [CLS_W-1:0] prod,
                                               input logic [CLS_W-1:0] cons);
    logic [CNT_W-1:0] g;
    g = '0;
    if (prod == CLS_FPALU && cons == CLS_FPALU)  g = 2'd3;
    if (prod == CLS_FPALU && cons == CLS_STORED) g = 2'd2;
    if (prod == CLS_LOADD && cons == CLS_FPALU)  g = 2'd1;
    return g;
  endfunction

  // Largest spacing any consumer may require from a producer class
  function automatic logic [CNT_W-1:0] maxGap(input logic [CLS_W-1:0] prod);
    logic [CNT_W-1:0] g;
    case (prod)
      CLS_FPALU: g = 2'd3;
      CLS_LOADD: g = 2'd1;
      default:   g = 2'd0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
  import ilk_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sbStrobe_t        strobe,
  input  logic [IDX_W-1:0] srcA,
  input  logic [IDX_W-1:0] srcB,
  input  logic [IDX_W-1:0] dst,
  input  logic [CLS_W-1:0] wrClass,
  output logic [CNT_W-1:0] cntA,
  output logic [CLS_W-1:0] clsA,
  output logic [CNT_W-1:0] cntB,
  output logic [CLS_W-1:0] clsB
);

  logic [CNT_W-1:0] intCnt [NUM_REGS];
  logic [CLS_W-1:0] intCls [NUM_REGS];
  logic [CNT_W-1:0] fpCnt  [NUM_REGS];
  logic [CLS_W-1:0] fpCls  [NUM_REGS];

  for (genvar f = 0; f < 2; f++) begin : g_file
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic hit;
      logic [CNT_W-1:0] cnt;
      logic [CLS_W-1:0] cls;
      assign hit = strobe.wrEn && (strobe.wrFp == (f == 1)) && (dst == IDX_W'(r));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
          cls <= CLS_NOP;
        end else if (hit) begin
          cnt <= maxGap(wrClass);
          cls <= wrClass;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end
      if (f == 1) begin : g_fp
        assign fpCnt[r] = cnt;
        assign fpCls[r] = cls;
      end else begin : g_int
        assign intCnt[r] = cnt;
        assign intCls[r] = cls;
      end
    end
  end

  assign cntA = strobe.rdFpA ? fpCnt[srcA] : intCnt[srcA];
  assign clsA = strobe.rdFpA ? fpCls[srcA] : intCls[srcA];
  assign cntB = strobe.rdFpB ? fpCnt[srcB] : intCnt[srcB];
  assign clsB = strobe.rdFpB ? fpCls[srcB] : intCls[srcB];

endmodule

// File: rtl/ilk_control.sv
module ilk_control
  import ilk_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decValid,
  input  logic [CLS_W-1:0] decClass,
  input  logic [IDX_W-1:0] srcA,
  input  logic [IDX_W-1:0] srcB,
  input  logic [IDX_W-1:0] dst,
  input  logic [CNT_W-1:0] cntA,
  input  logic [CLS_W-1:0] clsA,
  input  logic [CNT_W-1:0] cntB,
  input  logic [CLS_W-1:0] clsB,
  output sbStrobe_t        strobe,
  output logic             issue,
  output logic             stall,
  output logic             bubble
);

  logic useA, useB, hasDst, dstFp;
  logic hazA, hazB, slotPending;

  // Operand file map per class
  always_comb begin
    useA = 1'b0; useB = 1'b0; hasDst = 1'b0; dstFp = 1'b0;
    strobe.rdFpA = 1'b0;
    strobe.rdFpB = 1'b0;
    case (decClass)
      CLS_INT:    begin useA = 1'b1; useB = 1'b1; hasDst = 1'b1; end
      CLS_FPALU:  begin useA = 1'b1; useB = 1'b1; hasDst = 1'b1; dstFp = 1'b1;
                        strobe.rdFpA = 1'b1; strobe.rdFpB = 1'b1; end
      CLS_LOADD:  begin useA = 1'b1; hasDst = 1'b1; dstFp = 1'b1; end
      CLS_STORED: begin useA = 1'b1; useB = 1'b1; strobe.rdFpB = 1'b1; end
      CLS_BRANCH: begin useA = 1'b1; end
      default:    ;
    endcase
  end

  // Integer register 0 never creates a hazard
  logic liveA, liveB;
  assign liveA = useA && (strobe.rdFpA || srcA != '0);
  assign liveB = useB && (strobe.rdFpB || srcB != '0);

  assign hazA = liveA &&
    (({1'b0, cntA} + {1'b0, needGap(clsA, decClass)}) > {1'b0, maxGap(clsA)});
  assign hazB = liveB &&
    (({1'b0, cntB} + {1'b0, needGap(clsB, decClass)}) > {1'b0, maxGap(clsB)});

  assign issue  = decValid && (slotPending || !(hazA || hazB));
  assign stall  = decValid && !issue;
  assign bubble = !issue;

  assign strobe.wrEn = issue && hasDst && (dstFp || dst != '0);
  assign strobe.wrFp = dstFp;

  always_ff @(posedge clk) begin
    if (!rst_n)     slotPending <= 1'b0;
    else if (issue) slotPending <= (decClass == CLS_BRANCH);
  end

endmodule

// File: rtl/ilk_top.sv
module ilk_top
  import ilk_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decValid,
  input  logic [CLS_W-1:0] decClass,
  input  logic [IDX_W-1:0] decSrcA,
  input  logic [IDX_W-1:0] decSrcB,
  input  logic [IDX_W-1:0] decDst,
  output logic             issue,
  output logic             stall,
  output logic             bubble
);

  sbStrobe_t        strobe;
  logic [CNT_W-1:0] cntA, cntB;
  logic [CLS_W-1:0] clsA, clsB;

  ilk_control #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .decValid(decValid), .decClass(decClass),
    .srcA(decSrcA), .srcB(decSrcB), .dst(decDst),
    .cntA(cntA), .clsA(clsA), .cntB(cntB), .clsB(clsB),
    .strobe(strobe), .issue(issue), .stall(stall), .bubble(bubble)
  );

  ilk_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .srcA(decSrcA), .srcB(decSrcB), .dst(decDst), .wrClass(decClass),
    .cntA(cntA), .clsA(clsA), .cntB(cntB), .clsB(clsB)
  );

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             decValid,
  input logic [2:0]       decClass,
  input logic [IDX_W-1:0] decSrcA,
  input logic [IDX_W-1:0] decSrcB,
  input logic [IDX_W-1:0] decDst,
  input logic             issue,
  input logic             stall,
  input logic             bubble
);

  a_r8_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (bubble && !issue));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !decValid |-> (!issue && !stall));

  a_r7_delay_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && decClass == 3'd4) |=> (!decValid || issue));

  a_r2_fp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && decClass == 3'd1) |=>
      !(issue && decClass == 3'd1 &&
        (decSrcA == $past(decDst) || decSrcB == $past(decDst))));

  a_r4_load_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && decClass == 3'd2) |=>
      !(issue && decClass == 3'd1 &&
        (decSrcA == $past(decDst) || decSrcB == $past(decDst))));

endmodule

bind ilk_top ilk_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .decValid(decValid), .decClass(decClass),
  .decSrcA(decSrcA), .decSrcB(decSrcB), .decDst(decDst),
  .issue(issue), .stall(stall), .bubble(bubble)
);

// File: tb/ilk_top_bench.sv
`timescale 1ns/1ps
module ilk_top_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic decValid = 1'b0;
  logic [2:0] decClass = 3'd5;
  logic [4:0] decSrcA = '0, decSrcB = '0, decDst = '0;
  logic issue, stall, bubble;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  ilk_top u_ilk_top (
    .clk(clk), .rst_n(rst_n), .decValid(decValid), .decClass(decClass),
    .decSrcA(decSrcA), .decSrcB(decSrcB), .decDst(decDst),
    .issue(issue), .stall(stall), .bubble(bubble)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gapOf(input int p, input int c);
    if (p == 1 && c == 1) return 3;
    if (p == 1 && c == 3) return 2;
    if (p == 2 && c == 1) return 1;
    return 0;
  endfunction

  // Drive one instruction until it issues; returns stall cycles
  task automatic runInstr(input int c, input int a, input int b, input int d,
                          output int stalls);
    stalls = 0;
    @(negedge clk);
    decValid = 1'b1;
    decClass = 3'(c);
    decSrcA = 5'(a); decSrcB = 5'(b); decDst = 5'(d);
    #1;
    while (!issue && stalls < 20) begin
      stalls++;
      check(stall && bubble, "R8 stall/bubble", {stall, bubble}, 3);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic nops(input int n);
    int s;
    for (int i = 0; i < n; i++) runInstr(5, 0, 0, 0, s);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: idle decode
    #1;
    check(!issue && !stall && bubble, "R10 idle outputs", {issue, stall, bubble}, 1);

    // R1: FP read right after reset issues immediately
    runInstr(1, 4, 5, 6, s);
    check(s == 0, "R1 first issue", s, 0);
    nops(4);

    // R2/R3/R4/R5 sweep over producer, consumer and filler count
    for (int p = 0; p < 3; p++) begin
      for (int ci = 0; ci < 3; ci++) begin
        for (int g = 0; g < 4; g++) begin
          int c, exp, ea, eb;
          bit dep;
          c = (ci == 0) ? 0 : (ci == 1) ? 1 : 3;
          runInstr(p, 9, 9, 4, s);
          nops(g);
          ea = (c == 3) ? 9 : 4;
          eb = (c == 3) ? 4 : 9;
          runInstr(c, ea, eb, 10, s);
          dep = ((p != 0) == (c != 0));
          exp = dep ? ((gapOf(p, c) > g) ? gapOf(p, c) - g : 0) : 0;
          check(s == exp, "R2/R3/R4/R5 spacing sweep", s, exp);
          nops(4);
        end
      end
    end

    // R11: classes 6 and 7 behave as NOPs
    runInstr(1, 9, 9, 4, s);
    runInstr(6, 4, 4, 4, s);
    check(s == 0, "R11 code 6 nop", s, 0);
    runInstr(7, 4, 4, 4, s);
    check(s == 0, "R11 code 7 nop", s, 0);
    runInstr(1, 4, 9, 11, s);
    check(s == 1, "R11 nop writes nothing", s, 1);
    nops(4);

    // R6: store base in integer file, no stall from FP reg of same number
    runInstr(1, 9, 9, 4, s);
    runInstr(3, 4, 7, 0, s);
    check(s == 0, "R6 store base integer", s, 0);
    nops(4);

    // R7: delay slot overrides a live hazard
    runInstr(1, 9, 9, 4, s);
    runInstr(4, 1, 0, 0, s);
    runInstr(1, 4, 9, 12, s);
    check(s == 0, "R7 delay slot issue", s, 0);
    nops(4);

    // R9: vector add-scalar loop, three iterations
    for (int it = 0; it < 3; it++) begin
      int sAdd, sSt, total;
      total = 0;
      runInstr(2, 1, 0, 0, s);  total += 1 + s;
      runInstr(1, 0, 2, 4, sAdd); total += 1 + sAdd;
      runInstr(3, 1, 4, 0, sSt); total += 1 + sSt;
      runInstr(0, 1, 0, 1, s);  total += 1 + s;
      runInstr(4, 1, 0, 0, s);  total += 1 + s;
      runInstr(5, 0, 0, 0, s);  total += 1 + s;
      check(sAdd == 1, "R9 stall before add", sAdd, 1);
      check(sSt == 2, "R9 stalls before store", sSt, 2);
      check(total == 9, "R9 cycles per iteration", total, 9);
    end

    @(negedge clk);
    decValid = 1'b0;
    #1;
    check(!issue && !stall && bubble, "R10 idle at end", {issue, stall, bubble}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule